// File: doc/BRIEF.md
# Gray-Scale Pattern Dither Unit

This unit turns 2-bit pixel codes into the single on/off bit that a monochrome panel receives for each dot in each frame. Codes 0 and 3 give solid off and solid on. Codes 1 and 2 give two intermediate shades. Each of these two codes reads its own host-written pattern table. A table holds sixteen 4x4 dot patterns. The frame counter picks the pattern, so a shade changes over time. The low bits of the line and column pick the dot within that pattern, so a shade also varies across space. The same mechanism can map the four codes onto the four tints of a reflective color panel.

A host loads the 64 table bytes through a simple write port, and those bytes go into a staging copy. When a frame-start pulse arrives, the whole staging copy moves into the copy that drives lookups. A pattern therefore never changes partway through a frame. Pixels enter with a valid flag, and the result appears one clock later.

Top module: `gray_dither`

## Requirements
- R1: A valid pixel with code 0 gives `dot_o` = 0 on the next cycle.
- R2: A valid pixel with code 3 gives `dot_o` = 1 on the next cycle.
- R3: A valid pixel with code 1 reads table 0. The pattern is `frame_i` mod 16, the row is `y_i` mod 4 and the column is `x_i` mod 4.
- R4: A valid pixel with code 2 reads table 1, using the same pattern, row and column selection as R3.
- R5: Each table byte has an address. Bit 5 selects the table, bits 4:1 select the pattern, and bit 0 selects the row pair (0 for rows 0-1, 1 for rows 2-3). In each byte, the low nibble holds the even row and the high nibble holds the odd row. Within a nibble, bit 3 is column 0 and bit 0 is column 3.
- R6: A write goes only to the staging copy. It does not change any output until a later `frame_start_i` pulse copies the staging copy into the active copy.
- R7: `dot_valid_o` equals `pix_valid_i` delayed by one cycle. `dot_o` is 0 whenever `dot_valid_o` is 0.
- R8: Reset clears both the staging and active copies of every table byte to zero. It also clears `dot_o` and `dot_valid_o`.
- R9: When a write and `frame_start_i` occur in the same cycle, the commit takes the staging contents from before that write. The written byte becomes visible only after the next `frame_start_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Table byte write strobe |
| wr_addr_i | input | 6 | Table byte address (layout in R5) |
| wr_data_i | input | 8 | Table byte data |
| frame_start_i | input | 1 | Commits the staging tables to the active tables |
| frame_i | input | FRAME_W (8) | Frame counter; the low 4 bits select the pattern |
| pix_valid_i | input | 1 | Pixel input valid |
| pix_code_i | input | 2 | Pixel gray code |
| x_i | input | X_W (10) | Pixel column |
| y_i | input | Y_W (9) | Pixel line |
| dot_valid_o | output | 1 | Output dot valid |
| dot_o | output | 1 | Dithered dot for this frame |

## Verification
The hardest case to reach from the ports is one where the staging and active copies differ. This happens when a write is pending but not yet committed, and most of all when a write and a commit land in the same cycle. The stimulus writes a byte and looks up that byte's dot before committing. It repeats the write together with a frame pulse and checks that the dot still shows the old value. It then commits again and checks that the new value appears. Random batches of writes are mixed with occasional commits, so pending and committed contents diverge often while random pixels are looked up.

// File: rtl/gray_dither_pkg.sv
package gray_dither_pkg;
  localparam int PAT_DIM       = 4;
  localparam int NUM_PAT       = 16;
  localparam int NUM_TBL       = 2;
  localparam int BYTES_PER_PAT = PAT_DIM * PAT_DIM / 8;
  localparam int TBL_BYTES     = NUM_PAT * BYTES_PER_PAT;
  localparam int TOT_BYTES     = NUM_TBL * TBL_BYTES;
  localparam int ADDR_W        = $clog2(TOT_BYTES);
  localparam int PAT_W         = $clog2(NUM_PAT);
  localparam int DIM_W         = $clog2(PAT_DIM);

  typedef enum logic [1:0] {
    CODE_OFF = 2'd0,
    CODE_LO  = 2'd1,
    CODE_HI  = 2'd2,
    CODE_ON  = 2'd3
  } gray_code_e;

  typedef logic [7:0] tbl_byte_t;
endpackage

// File: rtl/dith_table_bank.sv
module dith_table_bank
  import gray_dither_pkg::*;
(
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           wr_en_i,
  input  logic [ADDR_W-1:0]              wr_addr_i,
  input  tbl_byte_t                      wr_data_i,
  input  logic                           commit_i,
  output logic [TOT_BYTES-1:0][7:0]      active_o
);
  logic [TOT_BYTES-1:0][7:0] stage_q;
  logic [TOT_BYTES-1:0][7:0] active_q;

  for (genvar b = 0; b < TOT_BYTES; b++) begin : g_byte
    logic hit;
    assign hit = wr_en_i && (wr_addr_i == ADDR_W'(b));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        stage_q[b]  <= '0;
        active_q[b] <= '0;
      end else begin
        if (hit)      stage_q[b]  <= wr_data_i;
        // commit sees pre-write staging contents
        if (commit_i) active_q[b] <= stage_q[b];
      end
    end
  end

  assign active_o = active_q;
endmodule

// File: rtl/dith_pattern_pick.sv
module dith_pattern_pick
  import gray_dither_pkg::*;
(
  input  logic [TOT_BYTES-1:0][7:0] bank_i,
  input  gray_code_e                code_i,
  input  logic [PAT_W-1:0]          pat_i,
  input  logic [DIM_W-1:0]          row_i,
  input  logic [DIM_W-1:0]          col_i,
  output logic                      dot_o
);
  logic [ADDR_W-1:0] idx;
  tbl_byte_t         sel_byte;
  logic [2:0]        bit_pos;

  always_comb begin
    idx      = {code_i == CODE_HI, pat_i, row_i[1]};
    sel_byte = bank_i[idx];
    // odd row in high nibble, leftmost column at nibble msb
    bit_pos  = {row_i[0], ~col_i};
    unique case (code_i)
      CODE_OFF: dot_o = 1'b0;
      CODE_ON:  dot_o = 1'b1;
      default:  dot_o = sel_byte[bit_pos];
    endcase
  end
endmodule

// File: rtl/gray_dither.sv
module gray_dither
  import gray_dither_pkg::*;
#(
  parameter int FRAME_W = 8,
  parameter int X_W     = 10,
  parameter int Y_W     = 9
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_en_i,
  input  logic [5:0]         wr_addr_i,
  input  logic [7:0]         wr_data_i,
  input  logic               frame_start_i,
  input  logic [FRAME_W-1:0] frame_i,
  input  logic               pix_valid_i,
  input  logic [1:0]         pix_code_i,
  input  logic [X_W-1:0]     x_i,
  input  logic [Y_W-1:0]     y_i,
  output logic               dot_valid_o,
  output logic               dot_o
);
  logic [TOT_BYTES-1:0][7:0] bank;
  logic                      dot_d;

  dith_table_bank u_bank (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_addr_i (wr_addr_i[ADDR_W-1:0]),
    .wr_data_i (wr_data_i),
    .commit_i  (frame_start_i),
    .active_o  (bank)
  );

  dith_pattern_pick u_pick (
    .bank_i (bank),
    .code_i (gray_code_e'(pix_code_i)),
    .pat_i  (frame_i[PAT_W-1:0]),
    .row_i  (y_i[DIM_W-1:0]),
    .col_i  (x_i[DIM_W-1:0]),
    .dot_o  (dot_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dot_valid_o <= 1'b0;
      dot_o       <= 1'b0;
    end else begin
      dot_valid_o <= pix_valid_i;
      dot_o       <= pix_valid_i & dot_d;
    end
  end
endmodule

// File: rtl/gray_dither_chk.sv
module gray_dither_chk #(
  parameter int FRAME_W = 8,
  parameter int X_W     = 10,
  parameter int Y_W     = 9
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               wr_en_i,
  input logic [5:0]         wr_addr_i,
  input logic [7:0]         wr_data_i,
  input logic               frame_start_i,
  input logic [FRAME_W-1:0] frame_i,
  input logic               pix_valid_i,
  input logic [1:0]         pix_code_i,
  input logic [X_W-1:0]     x_i,
  input logic [Y_W-1:0]     y_i,
  input logic               dot_valid_o,
  input logic               dot_o
);
  a_r1_code0_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pix_valid_i && pix_code_i == 2'd0) |=> (dot_valid_o && !dot_o));

  a_r2_code3_on: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pix_valid_i && pix_code_i == 2'd3) |=> (dot_valid_o && dot_o));

  a_r7_valid_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pix_valid_i |=> dot_valid_o);

  a_r7_idle_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pix_valid_i |=> (!dot_valid_o && !dot_o));

  a_r8_reset_out: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> (!dot_valid_o && !dot_o));
endmodule

bind gray_dither gray_dither_chk #(
  .FRAME_W(FRAME_W), .X_W(X_W), .Y_W(Y_W)
) u_chk (.*);

// File: tb/gray_dither_test.sv
module gray_dither_test;
  logic       clk_i = 0;
  logic       rst_ni = 0;
  logic       wr_en_i = 0;
  logic [5:0] wr_addr_i = '0;
  logic [7:0] wr_data_i = '0;
  logic       frame_start_i = 0;
  logic [7:0] frame_i = '0;
  logic       pix_valid_i = 0;
  logic [1:0] pix_code_i = '0;
  logic [9:0] x_i = '0;
  logic [8:0] y_i = '0;
  logic       dot_valid_o, dot_o;

  int total = 0, bad = 0;
  logic [7:0] stage_m [64];
  logic [7:0] act_m [64];

  always #5 clk_i = ~clk_i;

  gray_dither uut (.*);

  function automatic logic exp_dot(logic [1:0] c, logic [9:0] x, logic [8:0] y, logic [7:0] f);
    logic [7:0] b;
    if (c == 2'd0) return 1'b0;
    if (c == 2'd3) return 1'b1;
    b = act_m[{c == 2'd2, f[3:0], y[1]}];
    return b[y[0] * 4 + 3 - x[1:0]];
  endfunction

  task automatic chk(string req, logic act, logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0b exp=%0b", req, act, exp);
    end
  endtask

  task automatic wr(logic [5:0] a, logic [7:0] d, logic commit);
    @(negedge clk_i);
    wr_en_i = 1; wr_addr_i = a; wr_data_i = d; frame_start_i = commit;
    if (commit) foreach (act_m[i]) act_m[i] = stage_m[i];
    stage_m[a] = d;
    @(negedge clk_i);
    wr_en_i = 0; frame_start_i = 0;
  endtask

  task automatic commit();
    @(negedge clk_i);
    frame_start_i = 1;
    foreach (act_m[i]) act_m[i] = stage_m[i];
    @(negedge clk_i);
    frame_start_i = 0;
  endtask

  task automatic pix(string req, logic [1:0] c, logic [9:0] x, logic [8:0] y, logic [7:0] f);
    @(negedge clk_i);
    pix_valid_i = 1; pix_code_i = c; x_i = x; y_i = y; frame_i = f;
    @(negedge clk_i);
    pix_valid_i = 0;
    chk({req, " valid"}, dot_valid_o, 1'b1);
    chk(req, dot_o, exp_dot(c, x, y, f));
  endtask

  task automatic pix_lit(string req, logic [1:0] c, logic [9:0] x, logic [8:0] y, logic [7:0] f, logic e);
    @(negedge clk_i);
    pix_valid_i = 1; pix_code_i = c; x_i = x; y_i = y; frame_i = f;
    @(negedge clk_i);
    pix_valid_i = 0;
    chk(req, dot_o, e);
  endtask

  initial begin
    #2_000_000;
    bad++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h1bad5eed));
    foreach (stage_m[i]) begin stage_m[i] = 0; act_m[i] = 0; end
    repeat (3) @(negedge clk_i);
    chk("R8 reset valid", dot_valid_o, 1'b0);
    chk("R8 reset dot", dot_o, 1'b0);
    rst_ni = 1;
    @(negedge clk_i);
    chk("R7 idle valid", dot_valid_o, 1'b0);
    // zeroed tables
    for (int f = 0; f < 16; f++) begin
      pix_lit("R8 zero table0", 2'd1, 10'(f), 9'(f * 3), 8'(f), 1'b0);
      pix_lit("R8 zero table1", 2'd2, 10'(f + 1), 9'(f), 8'(f), 1'b0);
    end
    pix_lit("R1 code0", 2'd0, 10'd5, 9'd7, 8'd1, 1'b0);
    pix_lit("R2 code3", 2'd3, 10'd5, 9'd7, 8'd1, 1'b1);

    // R5 layout directed: addr 0 data 0x80 -> table0 pat0 row1 col0
    wr(6'h00, 8'h80, 1'b0);
    pix_lit("R6 staged not visible", 2'd1, 10'd0, 9'd1, 8'd0, 1'b0);
    commit();
    pix_lit("R5 row1 col0 on", 2'd1, 10'd0, 9'd1, 8'd0, 1'b1);
    pix_lit("R5 row0 col0 off", 2'd1, 10'd0, 9'd0, 8'd0, 1'b0);
    pix_lit("R5 row1 col1 off", 2'd1, 10'd1, 9'd1, 8'd0, 1'b0);
    pix_lit("R4 other table off", 2'd2, 10'd0, 9'd1, 8'd0, 1'b0);
    // table1 pattern 5 byte 1 = 0x01 -> row2 col3
    wr(6'h2B, 8'h01, 1'b0);
    commit();
    pix_lit("R5 t1 row2 col3", 2'd2, 10'd7, 9'd6, 8'h15, 1'b1);
    pix_lit("R3 t0 unaffected", 2'd1, 10'd7, 9'd6, 8'h15, 1'b0);

    // R9 write with commit in the same cycle
    wr(6'h01, 8'hFF, 1'b1);
    pix_lit("R9 same-cycle write hidden", 2'd1, 10'd2, 9'd2, 8'd0, 1'b0);
    commit();
    pix_lit("R9 visible after next commit", 2'd1, 10'd2, 9'd2, 8'd0, 1'b1);

    // random
    for (int r = 0; r < 40; r++) begin
      for (int k = 0; k < 6; k++) wr(6'($urandom), 8'($urandom), 1'($urandom % 4 == 0));
      if ($urandom % 2) commit();
      for (int k = 0; k < 10; k++)
        pix("R3R4 random", 2'($urandom), 10'($urandom), 9'($urandom), 8'($urandom));
    end
    // R7 idle after activity
    @(negedge clk_i);
    chk("R7 idle valid", dot_valid_o, 1'b0);
    chk("R7 idle dot", dot_o, 1'b0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule